// File: doc/BRIEF.md
# Synthetic Traffic Source for a Mesh Network Node

This block sits on the injection side of one node in a square mesh network-on-chip. It produces destination addresses and a send strobe so the network can be loaded and measured under known traffic. Each node gets its own coordinate address, a pattern code and a hot-spot address. From these it picks where each packet goes. The choice is either random, drawn from a 16-bit linear feedback shift register, or a fixed permutation of the node's own coordinates.

The time between sends comes from one of two sources. The first is a fixed gap taken from an input. The second is a sequence of pseudo-random gaps held in a small constant table that is read in order. A down-counter is loaded with the gap each time a send fires. The next send becomes due when the counter reaches zero.

A due send that cannot leave is held rather than dropped. This happens when the output slot is still occupied or the random draw is unusable. While it is held, the counter stays at zero and is not reloaded. Configuration is expected to be changed only while reset is asserted.

Top module: `tgen_traffic_src`

## Requirements
- R1: While reset is asserted, snd_vld is 0. In the first clock cycle after reset is released, a node whose pattern gives a usable destination presents a send.
- R2: With cfg_rand_gap=0, a fixed gap G and snd_rdy held at 1, consecutive accepted sends are exactly G+1 cycles apart. With G=0, a send is accepted every cycle.
- R3: With cfg_rand_gap=1, the gap after the j-th send (j counted from 0) is T[j mod 16]+1 cycles, with T[i] = (13·i² + 7·i + 5) mod 256, and cfg_fixed_gap has no effect. The table index advances only when a send fires.
- R4: While snd_vld=1 and snd_rdy=0, snd_vld stays 1 and snd_dst does not change. If the next send came due during the stall, it is presented in the cycle right after the stalled send is accepted. The gap after that send is one normal interval.
- R5: Addresses are {X, Y}, with X in bits [3:2] and Y in bits [1:0] of a 4×4 mesh. With pattern code 2, node {X,Y} sends to {(X+1) mod 4, Y}.
- R6: With pattern code 3, node {X,Y} sends to {Y,X}. A node with X=Y never sends.
- R7: With pattern code 4, every node sends to the bitwise inverse of its own address.
- R8: With pattern code 5, every send goes to cfg_hot_addr. A node whose own address equals the hot-spot address never sends.
- R9: With pattern code 0, the destination is drawn at random. It never equals the sender's own address, and every other node of the mesh is reached.
- R10: With pattern code 1, every destination is exactly one mesh hop from the sender. Draws that would leave the mesh are redrawn, so every in-mesh neighbour is reached, including at corners.
- R11: Pattern codes 6 and 7 produce no sends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_self_addr | input | 4 | This node's {X,Y} address |
| cfg_pattern | input | 3 | Traffic pattern code |
| cfg_hot_addr | input | 4 | Hot-spot destination address |
| cfg_rand_gap | input | 1 | 1: gaps from the constant table, 0: fixed gap |
| cfg_fixed_gap | input | 8 | Fixed gap value G |
| snd_rdy | input | 1 | Downstream accepts the presented send |
| snd_vld | output | 1 | A send is presented |
| snd_dst | output | 4 | Destination of the presented send |

## Verification
Each permutation pattern is applied from several node positions:
- Tornado is tried at the left edge and in the middle.
- Transpose is tried both on and off the diagonal.
- Hot-spot is tried with the node as a sender and as the hot-spot itself.

These runs separate a wrong axis, a missing modulo wrap and a failure to suppress self-addressed traffic. The random patterns are checked over many draws, for exclusion of the sender and for full coverage. The neighbour pattern is run at a corner node and at an interior node, which shows whether off-mesh draws are discarded and redrawn. Gap timing is compared cycle by cycle against the fixed setting and against the table sequence past its wrap. A long downstream stall shows whether a due send is lost or delayed by an extra interval.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

  typedef enum logic [2:0] {
    PAT_UNIFORM   = 3'd0,
    PAT_NEIGHBOUR = 3'd1,
    PAT_TORNADO   = 3'd2,
    PAT_TRANSPOSE = 3'd3,
    PAT_BITCOMP   = 3'd4,
    PAT_HOTSPOT   = 3'd5,
    PAT_IDLE6     = 3'd6,
    PAT_IDLE7     = 3'd7
  } tgen_pat_e;

  localparam int LFSR_W = 16;

  // Fibonacci shift register, taps 16,14,13,11 (maximal length)
  function automatic logic [LFSR_W-1:0] tgen_lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Pseudo-random gap table content, truncated by the user to its width
  function automatic int unsigned tgen_gap_word(input int unsigned idx);
    return 13 * idx * idx + 7 * idx + 5;
  endfunction

endpackage

// File: rtl/tgen_lfsr.sv
module tgen_lfsr #(
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter int          OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [tgen_pkg::LFSR_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= tgen_pkg::tgen_lfsr_step(state_q);
  end

  assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/tgen_dest.sv
module tgen_dest #(
  parameter  int K_DIM = 4,
  localparam int CW    = (K_DIM > 1) ? $clog2(K_DIM) : 1,
  localparam int AW    = 2 * CW
) (
  input  logic [AW-1:0] self_addr,
  input  logic [AW-1:0] hot_addr,
  input  logic [2:0]    pattern,
  input  logic [AW-1:0] rnd,
  output logic [AW-1:0] cand,
  output logic          cand_ok
);
  import tgen_pkg::*;

  localparam int          TORN_OFS = K_DIM / 2 - 1;
  localparam logic [CW-1:0] MAX_C  = CW'(K_DIM - 1);

  function automatic logic [CW-1:0] tornado_x(input logic [CW-1:0] c);
    return CW'((int'(c) + TORN_OFS) % K_DIM);
  endfunction

  tgen_pat_e     pat;
  logic [CW-1:0] sx, sy, tx;

  assign pat = tgen_pat_e'(pattern);
  assign sx  = self_addr[AW-1:CW];
  assign sy  = self_addr[CW-1:0];
  assign tx  = tornado_x(sx);

  always_comb begin
    cand    = '0;
    cand_ok = 1'b0;
    unique case (pat)
      PAT_UNIFORM: begin
        cand    = rnd;
        cand_ok = (rnd != self_addr);
      end
      PAT_NEIGHBOUR: begin
        unique case (rnd[1:0])
          2'd0: begin cand = {sx + CW'(1), sy}; cand_ok = (sx != MAX_C); end
          2'd1: begin cand = {sx - CW'(1), sy}; cand_ok = (sx != '0);    end
          2'd2: begin cand = {sx, sy + CW'(1)}; cand_ok = (sy != MAX_C); end
          default: begin cand = {sx, sy - CW'(1)}; cand_ok = (sy != '0); end
        endcase
      end
      PAT_TORNADO: begin
        cand    = {tx, sy};
        cand_ok = (tx != sx);
      end
      PAT_TRANSPOSE: begin
        cand    = {sy, sx};
        cand_ok = (sx != sy);
      end
      PAT_BITCOMP: begin
        cand    = ~self_addr;
        cand_ok = 1'b1;
      end
      PAT_HOTSPOT: begin
        cand    = hot_addr;
        cand_ok = (hot_addr != self_addr);
      end
      PAT_IDLE6, PAT_IDLE7: begin
        cand    = '0;
        cand_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/tgen_pacer.sv
module tgen_pacer #(
  parameter  int GAP_W     = 8,
  parameter  int ROM_DEPTH = 16,
  parameter  int AW        = 4,
  localparam int PW        = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rand_gap,
  input  logic [GAP_W-1:0] fixed_gap,
  input  logic [AW-1:0]    cand,
  input  logic             cand_ok,
  input  logic             rdy,
  output logic             vld,
  output logic [AW-1:0]    dst,
  output logic             fire
);
  localparam logic [PW-1:0] LAST_IDX = PW'(ROM_DEPTH - 1);

  logic [GAP_W-1:0] gap_rom [ROM_DEPTH];

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    assign gap_rom[g] = GAP_W'(tgen_pkg::tgen_gap_word(g));
  end

  logic [GAP_W-1:0] cnt_q;
  logic [PW-1:0]    ptr_q;
  logic             slot_free, due;
  logic [GAP_W-1:0] reload;

  assign due       = (cnt_q == '0);
  assign slot_free = !vld || rdy;
  assign fire      = due && slot_free && cand_ok;
  assign reload    = rand_gap ? gap_rom[ptr_q] : fixed_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
      vld   <= 1'b0;
      dst   <= '0;
    end else if (fire) begin
      cnt_q <= reload;
      vld   <= 1'b1;
      dst   <= cand;
      if (rand_gap) ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + PW'(1);
    end else begin
      if (!due) cnt_q <= cnt_q - GAP_W'(1);
      if (rdy)  vld   <= 1'b0;
    end
  end
endmodule

// File: rtl/tgen_traffic_src.sv
module tgen_traffic_src #(
  parameter  int          K_DIM     = 4,
  parameter  int          GAP_W     = 8,
  parameter  int          ROM_DEPTH = 16,
  parameter  logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int          CW        = (K_DIM > 1) ? $clog2(K_DIM) : 1,
  localparam int          AW        = 2 * CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cfg_self_addr,
  input  logic [2:0]       cfg_pattern,
  input  logic [AW-1:0]    cfg_hot_addr,
  input  logic             cfg_rand_gap,
  input  logic [GAP_W-1:0] cfg_fixed_gap,
  input  logic             snd_rdy,
  output logic             snd_vld,
  output logic [AW-1:0]    snd_dst
);
  logic [AW-1:0] rnd_bits;
  logic [AW-1:0] cand;
  logic          cand_ok;
  logic          fire_evt;

  tgen_lfsr #(.SEED(LFSR_SEED), .OUT_W(AW)) u_lfsr (
    .clk (clk),
    .rst_n (rst_n),
    .rnd (rnd_bits)
  );

  tgen_dest #(.K_DIM(K_DIM)) u_dest (
    .self_addr (cfg_self_addr),
    .hot_addr  (cfg_hot_addr),
    .pattern   (cfg_pattern),
    .rnd       (rnd_bits),
    .cand      (cand),
    .cand_ok   (cand_ok)
  );

  tgen_pacer #(.GAP_W(GAP_W), .ROM_DEPTH(ROM_DEPTH), .AW(AW)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rand_gap  (cfg_rand_gap),
    .fixed_gap (cfg_fixed_gap),
    .cand      (cand),
    .cand_ok   (cand_ok),
    .rdy       (snd_rdy),
    .vld       (snd_vld),
    .dst       (snd_dst),
    .fire      (fire_evt)
  );
endmodule

// File: rtl/tgen_traffic_src_chk.sv
module tgen_traffic_src_chk #(
  parameter  int K_DIM = 4,
  localparam int CW    = (K_DIM > 1) ? $clog2(K_DIM) : 1,
  localparam int AW    = 2 * CW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    pattern,
  input logic [AW-1:0] self_addr,
  input logic [AW-1:0] hot_addr,
  input logic          vld,
  input logic          rdy,
  input logic [AW-1:0] dst,
  input logic          fire
);
  int sx, sy, dx, dy, hops;

  always_comb begin
    sx   = int'(self_addr[AW-1:CW]);
    sy   = int'(self_addr[CW-1:0]);
    dx   = int'(dst[AW-1:CW]);
    dy   = int'(dst[CW-1:0]);
    hops = ((sx > dx) ? sx - dx : dx - sx) + ((sy > dy) ? sy - dy : dy - sy);
  end

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !rdy |=> vld && $stable(dst));

  // R9
  no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> dst != self_addr);

  // R10
  one_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld && pattern == 3'd1 |-> hops == 1);

  // R8
  hot_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld && pattern == 3'd5 |-> dst == hot_addr);

  // R5
  tornado_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld && pattern == 3'd2 |-> dy == sy && dx == (sx + K_DIM / 2 - 1) % K_DIM);

  // R11
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> pattern <= 3'd5);

  // R2
  fire_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> vld);
endmodule

bind tgen_traffic_src tgen_traffic_src_chk #(.K_DIM(K_DIM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pattern   (cfg_pattern),
  .self_addr (cfg_self_addr),
  .hot_addr  (cfg_hot_addr),
  .vld       (snd_vld),
  .rdy       (snd_rdy),
  .dst       (snd_dst),
  .fire      (fire_evt)
);

// File: tb/tgen_traffic_src_tb.sv
module tgen_traffic_src_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_self_addr = '0;
  logic [2:0] cfg_pattern = '0;
  logic [3:0] cfg_hot_addr = '0;
  logic       cfg_rand_gap = 1'b0;
  logic [7:0] cfg_fixed_gap = '0;
  logic       snd_rdy = 1'b1;
  logic       snd_vld;
  logic [3:0] snd_dst;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tgen_traffic_src u_dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_self_addr (cfg_self_addr), .cfg_pattern (cfg_pattern),
    .cfg_hot_addr (cfg_hot_addr), .cfg_rand_gap (cfg_rand_gap),
    .cfg_fixed_gap (cfg_fixed_gap), .snd_rdy (snd_rdy),
    .snd_vld (snd_vld), .snd_dst (snd_dst)
  );

  // {pattern, self, hot, expected dst, sends}
  localparam logic [15:0] VECS [11] = '{
    {3'd2, 4'h2, 4'h0, 4'h6, 1'b1},
    {3'd2, 4'hD, 4'h0, 4'h1, 1'b1},
    {3'd2, 4'h4, 4'h0, 4'h8, 1'b1},
    {3'd3, 4'h7, 4'h0, 4'hD, 1'b1},
    {3'd3, 4'hA, 4'h0, 4'h0, 1'b0},
    {3'd4, 4'h5, 4'h0, 4'hA, 1'b1},
    {3'd4, 4'h0, 4'h0, 4'hF, 1'b1},
    {3'd5, 4'h3, 4'h9, 4'h9, 1'b1},
    {3'd5, 4'h9, 4'h9, 4'h0, 1'b0},
    {3'd6, 4'h4, 4'h0, 4'h0, 1'b0},
    {3'd7, 4'h4, 4'h2, 4'h0, 1'b0}
  };

  function automatic string req_of(input logic [2:0] p);
    case (p)
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic int table_gap(input int i);
    return (5 + i * (7 + 13 * i)) % 256;
  endfunction

  function automatic bit adjacent(input logic [3:0] a, input logic [3:0] b);
    int ddx, ddy;
    ddx = int'(a[3:2]) - int'(b[3:2]);
    ddy = int'(a[1:0]) - int'(b[1:0]);
    return (ddx * ddx + ddy * ddy) == 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] pat, input logic [3:0] self_a,
                          input logic [3:0] hot, input logic rnd_mode,
                          input logic [7:0] gap, input logic rdy);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_pattern = pat; cfg_self_addr = self_a; cfg_hot_addr = hot;
    cfg_rand_gap = rnd_mode; cfg_fixed_gap = gap; snd_rdy = rdy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_accept(input int limit, output bit got, output int at,
                             output logic [3:0] d);
    got = 1'b0; at = 0; d = '0;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge clk);
      if (snd_vld && snd_rdy) begin got = 1'b1; at = cyc; d = snd_dst; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit got;
    int t0, t1;
    int times [20];
    logic [3:0] d, held;
    bit seen [16];
    int bad;

    // R1: outputs quiet under reset
    repeat (2) @(negedge clk);
    check(snd_vld == 1'b0, "R1", "vld in reset", int'(snd_vld), 0);

    // Table walk over deterministic patterns
    for (int v = 0; v < 11; v++) begin
      logic [2:0] p; logic [3:0] s, h, e; bit sends; int hits;
      {p, s, h, e, sends} = VECS[v];
      do_reset(p, s, h, 1'b0, 8'd2, 1'b1);
      check(snd_vld == 1'b0, "R1", "vld while reset held", int'(snd_vld), 0);
      @(negedge clk);
      check(snd_vld == sends, "R1", "first-cycle strobe", int'(snd_vld), int'(sends));
      if (sends) check(snd_dst == e, req_of(p), "destination", int'(snd_dst), int'(e));
      else begin
        hits = 0;
        repeat (40) begin @(negedge clk); if (snd_vld) hits++; end
        check(hits == 0, req_of(p), "idle node strobes", hits, 0);
      end
    end

    // R2: fixed gap spacing
    do_reset(3'd5, 4'h0, 4'h5, 1'b0, 8'd5, 1'b1);
    wait_accept(10, got, t0, d);
    check(got, "R2", "first send", int'(got), 1);
    for (int j = 0; j < 4; j++) begin
      wait_accept(20, got, t1, d);
      check(got && (t1 - t0) == 6, "R2", "fixed gap", t1 - t0, 6);
      t0 = t1;
    end
    do_reset(3'd5, 4'h0, 4'h5, 1'b0, 8'd0, 1'b1);
    bad = 0;
    repeat (8) begin @(negedge clk); if (!snd_vld) bad++; end
    check(bad == 0, "R2", "gap zero missing strobes", bad, 0);

    // R3: table-driven gaps across wrap, fixed gap ignored
    do_reset(3'd5, 4'h0, 4'h5, 1'b1, 8'd3, 1'b1);
    for (int j = 0; j < 20; j++) begin
      wait_accept(400, got, times[j], d);
      check(got, "R3", "send arrived", int'(got), 1);
    end
    for (int j = 0; j < 19; j++)
      check((times[j+1] - times[j]) == table_gap(j % 16) + 1, "R3", "table gap",
            times[j+1] - times[j], table_gap(j % 16) + 1);

    // R4: stall keeps destination, due send follows at once
    do_reset(3'd0, 4'h6, 4'h0, 1'b0, 8'd2, 1'b0);
    @(negedge clk);
    held = snd_dst;
    bad = 0;
    repeat (10) begin @(negedge clk); if (!snd_vld || snd_dst != held) bad++; end
    check(bad == 0, "R4", "stalled send changed", bad, 0);
    do_reset(3'd5, 4'h1, 4'hE, 1'b0, 8'd2, 1'b0);
    repeat (8) @(negedge clk);
    snd_rdy = 1'b1;
    t0 = cyc;
    @(negedge clk);
    check(snd_vld && (cyc - t0) == 1, "R4", "due send after accept", int'(snd_vld), 1);
    t0 = cyc;
    wait_accept(10, got, t1, d);
    check(got && (t1 - t0) == 3, "R4", "interval after stall", t1 - t0, 3);

    // R9: uniform random coverage
    do_reset(3'd0, 4'h6, 4'h0, 1'b0, 8'd0, 1'b1);
    foreach (seen[i]) seen[i] = 1'b0;
    bad = 0;
    repeat (400) begin
      @(negedge clk);
      if (snd_vld) begin seen[snd_dst] = 1'b1; if (snd_dst == 4'h6) bad++; end
    end
    check(bad == 0, "R9", "self-addressed sends", bad, 0);
    bad = 0;
    for (int i = 0; i < 16; i++) if (i != 6 && !seen[i]) bad++;
    check(bad == 0, "R9", "unreached nodes", bad, 0);

    // R10: neighbour pattern at corner and interior
    for (int k = 0; k < 2; k++) begin
      logic [3:0] me; int miss;
      me = (k == 0) ? 4'h0 : 4'h5;
      do_reset(3'd1, me, 4'h0, 1'b0, 8'd0, 1'b1);
      foreach (seen[i]) seen[i] = 1'b0;
      bad = 0;
      repeat (300) begin
        @(negedge clk);
        if (snd_vld) begin seen[snd_dst] = 1'b1; if (!adjacent(snd_dst, me)) bad++; end
      end
      check(bad == 0, "R10", "non-adjacent sends", bad, 0);
      miss = 0;
      for (int i = 0; i < 16; i++) if (adjacent(4'(i), me) && !seen[i]) miss++;
      check(miss == 0, "R10", "unreached neighbours", miss, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule